// File: doc/BRIEF.md
# Lockable Identification Page Write Controller

This block sits beside the write path of a serial memory slave and handles a separate 32-byte identification page. It responds only to a device select code with type nibble `1011` and the write direction. After the two address bytes, the controller uses address bit A10 to pick one of two commands. With A10 clear it runs a page write into the identification page. With A10 set it runs a one-byte lock command, which sets a one-time lock flag.

The decoded bus events arrive as single-cycle strobes: a select code, the pair of address bytes, each data byte, and Stop. Stop comes with a qualifier that says whether it fell in the slot right after a data acknowledge. For each data byte the controller returns an acknowledge decision one cycle later. A qualifying Stop starts an internal write cycle of fixed length. During that cycle the staged bytes are copied into the page storage, or the lock flag is armed, and the controller answers nothing with an acknowledge. The lock flag is held in a register; keeping it after power-down is outside this block. A registered read port lets the neighbouring read logic fetch page bytes.

Top module: `idp_ctrl`

## Requirements
- R1: Only a select strobe with type `1011` and the read flag at 0 engages the block. Data bytes after any other select code produce no `ack_vld`.
- R2: With address bit A10 (bit 2 of `addr_hi`) at 0, the command is a page write. The first byte goes to page position `addr_lo[4:0]`, and all other address bits are ignored.
- R3: Each acknowledged page byte advances the in-page pointer by one, wrapping from 31 to 0. A later byte for the same position replaces the earlier one.
- R4: Staged bytes are written only by a Stop with `stop_slot` = 1 that follows at least one acknowledged byte. A Stop with `stop_slot` = 0 discards them and leaves `busy` low.
- R5: A committing Stop raises `busy` for exactly `TW_CYCLES` cycles. While `busy` is high, a data byte gets `ack_vld` = 1 with `ack` = 0, and a select code is ignored.
- R6: With A10 = 1, an acknowledged lock byte with bit 1 set, followed by a qualifying Stop, raises `locked` in the cycle that `busy` falls.
- R7: A lock byte with bit 1 at 0 is acknowledged and runs a write cycle, but `locked` stays 0.
- R8: Once `locked` = 1, every data byte of either command gets `ack` = 0, the page contents are unchanged, and `locked` never returns to 0 except through reset.
- R9: While `wc` is 1, data bytes get `ack` = 0 and are not staged. A lock byte refused this way sets no lock.
- R10: After reset, `ack_vld`, `ack`, `busy` and `locked` are 0.
- R11: `ack_vld` pulses exactly one cycle after a `data_vld` strobe that comes while the block is engaged or busy. In the lock command, only the first data byte can be acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_vld | input | 1 | Strobe: a select code was received |
| sel_type | input | 4 | Device type nibble of the select code |
| sel_rd | input | 1 | Direction bit of the select code (1 = read) |
| addr_vld | input | 1 | Strobe: both address bytes were received |
| addr_hi | input | 8 | Most significant address byte |
| addr_lo | input | 8 | Least significant address byte |
| data_vld | input | 1 | Strobe: a data byte was received |
| data_byte | input | 8 | Received data byte |
| stop_det | input | 1 | Strobe: Stop condition |
| stop_slot | input | 1 | Stop fell right after a data acknowledge |
| wc | input | 1 | Write control; 1 refuses writes |
| rd_addr | input | PW | Page read address for the neighbour read logic |
| ack_vld | output | 1 | An acknowledge decision is present |
| ack | output | 1 | 1 = Ack, 0 = NoAck |
| busy | output | 1 | Internal write cycle in progress |
| locked | output | 1 | Identification page is locked |
| rd_data | output | 8 | Page byte, one cycle after `rd_addr` |

## Verification
The hardest state to reach is the window where the controller is busy. A select code or data byte has to arrive inside that window, and the bench must still see that the select was ignored once `busy` drops. A directed probe therefore injects a data byte and a select code immediately after a committing Stop. After the write cycle ends it sends another data byte, which must get no response at all. Page wrap-around, lock bytes with bit 1 clear, and lock attempts under write control are driven as directed cases. Seeded random page writes with varying start, length, `wc`, select type and Stop slot are then run both before and after the lock is set.

// File: rtl/idp_pkg.sv
package idp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,   // not engaged
    ST_ADDR,   // select matched, waiting for address bytes
    ST_PAGE,   // page write data phase
    ST_LOCK,   // lock command, waiting for its byte
    ST_HOLD    // lock byte seen, further bytes refused
  } idp_state_t;
endpackage

// File: rtl/idp_cmd_fsm.sv
module idp_cmd_fsm
  import idp_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b1011,
  parameter int SEL_BIT  = 10,
  parameter int LOCK_BIT = 1,
  parameter int PW       = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_vld,
  input  logic [3:0]    sel_type,
  input  logic          sel_rd,
  input  logic          addr_vld,
  input  logic [7:0]    addr_hi,
  input  logic [7:0]    addr_lo,
  input  logic          data_vld,
  input  logic [7:0]    data_byte,
  input  logic          stop_det,
  input  logic          stop_slot,
  input  logic          wc,
  input  logic          busy,
  input  logic          locked,
  output logic          ack_vld,
  output logic          ack,
  output logic          stage_clr,
  output logic          stage_we,
  output logic [PW-1:0] stage_idx,
  output logic          commit_page,
  output logic          commit_lock,
  output logic          lock_arm
);
  localparam int HI_IDX = SEL_BIT - 8;

  idp_state_t    st;
  logic [PW-1:0] ptr;
  logic          staged;
  logic          accept;
  logic          qual_stop;
  logic          unused_addr;

  assign unused_addr = ^{addr_hi, addr_lo[7:PW]};

  assign accept    = data_vld && !wc && !locked && !busy &&
                     (st == ST_PAGE || st == ST_LOCK);
  assign qual_stop = stop_det && stop_slot && !busy && staged && !sel_vld;

  assign stage_clr   = (st == ST_ADDR) && addr_vld && !sel_vld && !stop_det;
  assign stage_we    = accept && (st == ST_PAGE);
  assign stage_idx   = ptr;
  assign commit_page = qual_stop && (st == ST_PAGE);
  assign commit_lock = qual_stop && (st == ST_HOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ptr      <= '0;
      staged   <= 1'b0;
      lock_arm <= 1'b0;
      ack_vld  <= 1'b0;
      ack      <= 1'b0;
    end else begin
      ack_vld <= data_vld && (busy || st != ST_IDLE);
      ack     <= accept;
      if (sel_vld && !busy) begin
        st <= (sel_type == DEV_TYPE && !sel_rd) ? ST_ADDR : ST_IDLE;
      end else if (stop_det) begin
        st <= ST_IDLE;
      end else begin
        unique case (st)
          ST_ADDR: if (addr_vld) begin
            st       <= addr_hi[HI_IDX] ? ST_LOCK : ST_PAGE;
            ptr      <= addr_lo[PW-1:0];
            staged   <= 1'b0;
            lock_arm <= 1'b0;
          end
          ST_PAGE: if (accept) begin
            ptr    <= ptr + 1'b1;
            staged <= 1'b1;
          end
          ST_LOCK: if (data_vld) begin
            st <= ST_HOLD;
            if (accept) begin
              staged   <= 1'b1;
              lock_arm <= data_byte[LOCK_BIT];
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/idp_stage.sv
module idp_stage #(
  parameter int PAGE_BYTES = 32,
  parameter int PW         = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          we,
  input  logic [PW-1:0] widx,
  input  logic [7:0]    wbyte,
  input  logic [PW-1:0] ridx,
  output logic [7:0]    rbyte,
  output logic          rvalid
);
  logic [7:0]            slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  always_ff @(posedge clk) begin
    if (we) slot_q[widx] <= wbyte;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) mask_q <= '0;
    else if (we)    mask_q[widx] <= 1'b1;
  end

  assign rbyte  = slot_q[ridx];
  assign rvalid = mask_q[ridx];
endmodule

// File: rtl/idp_page_ram.sv
module idp_page_ram #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/idp_ctrl.sv
module idp_ctrl
  import idp_pkg::*;
#(
  parameter int PAGE_BYTES = 32,
  parameter int TW_CYCLES  = 40,
  parameter int SEL_BIT    = 10,
  parameter int LOCK_BIT   = 1,
  parameter logic [3:0] DEV_TYPE = 4'b1011,
  localparam int PW = $clog2(PAGE_BYTES),
  localparam int CW = $clog2(TW_CYCLES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_vld,
  input  logic [3:0]    sel_type,
  input  logic          sel_rd,
  input  logic          addr_vld,
  input  logic [7:0]    addr_hi,
  input  logic [7:0]    addr_lo,
  input  logic          data_vld,
  input  logic [7:0]    data_byte,
  input  logic          stop_det,
  input  logic          stop_slot,
  input  logic          wc,
  input  logic [PW-1:0] rd_addr,
  output logic          ack_vld,
  output logic          ack,
  output logic          busy,
  output logic          locked,
  output logic [7:0]    rd_data
);
  logic          stage_clr, stage_we, commit_page, commit_lock, lock_arm;
  logic [PW-1:0] stage_idx;
  logic [7:0]    stage_rbyte;
  logic          stage_rvalid;
  logic [CW-1:0] cnt;
  logic          is_lock, do_lock;
  logic          ram_we;

  idp_cmd_fsm #(
    .DEV_TYPE(DEV_TYPE), .SEL_BIT(SEL_BIT), .LOCK_BIT(LOCK_BIT), .PW(PW)
  ) u_fsm (
    .clk(clk), .rst(rst),
    .sel_vld(sel_vld), .sel_type(sel_type), .sel_rd(sel_rd),
    .addr_vld(addr_vld), .addr_hi(addr_hi), .addr_lo(addr_lo),
    .data_vld(data_vld), .data_byte(data_byte),
    .stop_det(stop_det), .stop_slot(stop_slot), .wc(wc),
    .busy(busy), .locked(locked),
    .ack_vld(ack_vld), .ack(ack),
    .stage_clr(stage_clr), .stage_we(stage_we), .stage_idx(stage_idx),
    .commit_page(commit_page), .commit_lock(commit_lock), .lock_arm(lock_arm)
  );

  idp_stage #(.PAGE_BYTES(PAGE_BYTES), .PW(PW)) u_stage (
    .clk(clk), .rst(rst), .clr(stage_clr),
    .we(stage_we), .widx(stage_idx), .wbyte(data_byte),
    .ridx(cnt[PW-1:0]), .rbyte(stage_rbyte), .rvalid(stage_rvalid)
  );

  // Write cycle: walks the staged slots once, then finishes after TW_CYCLES.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      is_lock <= 1'b0;
      do_lock <= 1'b0;
      locked  <= 1'b0;
    end else if (!busy) begin
      if (commit_page || commit_lock) begin
        busy    <= 1'b1;
        cnt     <= '0;
        is_lock <= commit_lock;
        do_lock <= commit_lock && lock_arm;
      end
    end else if (cnt == CW'(TW_CYCLES - 1)) begin
      busy <= 1'b0;
      if (do_lock) locked <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ram_we = busy && !is_lock && (cnt < CW'(PAGE_BYTES)) && stage_rvalid;

  idp_page_ram #(.DEPTH(PAGE_BYTES), .AW(PW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(cnt[PW-1:0]), .wdata(stage_rbyte),
    .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/idp_ctrl_chk.sv
module idp_ctrl_chk #(
  parameter int TW_CYCLES = 40
) (
  input logic clk,
  input logic rst,
  input logic data_vld,
  input logic wc,
  input logic ack_vld,
  input logic ack,
  input logic busy,
  input logic locked,
  input logic ram_we
);
  int busy_len;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_len <= 0;
    else              busy_len <= busy_len + 1;
  end

  p_ack_follows_data_r11: assert property (@(posedge clk) disable iff (rst)
    ack_vld |-> $past(data_vld));
  p_nack_locked_r8: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && $past(locked)) |-> !ack);
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    $past(locked) |-> locked);
  p_nack_wc_r9: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && $past(wc)) |-> !ack);
  p_nack_busy_r5: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && $past(busy)) |-> !ack);
  p_busy_len_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == TW_CYCLES));
  p_lock_at_end_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $fell(busy));
  p_ram_in_cycle_r4: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> busy);
endmodule

bind idp_ctrl idp_ctrl_chk #(.TW_CYCLES(TW_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .data_vld(data_vld), .wc(wc),
  .ack_vld(ack_vld), .ack(ack), .busy(busy), .locked(locked),
  .ram_we(ram_we)
);

// File: tb/test_idp_ctrl.sv
module test_idp_ctrl;
  localparam int TW = 40;

  logic clk = 0, rst = 1;
  logic sel_vld = 0, sel_rd = 0, addr_vld = 0, data_vld = 0;
  logic stop_det = 0, stop_slot = 0, wc = 0;
  logic [3:0] sel_type = 0;
  logic [7:0] addr_hi = 0, addr_lo = 0, data_byte = 0;
  logic [4:0] rd_addr = 0;
  logic ack_vld, ack, busy, locked;
  logic [7:0] rd_data;

  idp_ctrl #(.TW_CYCLES(TW)) i_idp_ctrl (
    .clk(clk), .rst(rst), .sel_vld(sel_vld), .sel_type(sel_type),
    .sel_rd(sel_rd), .addr_vld(addr_vld), .addr_hi(addr_hi),
    .addr_lo(addr_lo), .data_vld(data_vld), .data_byte(data_byte),
    .stop_det(stop_det), .stop_slot(stop_slot), .wc(wc),
    .rd_addr(rd_addr), .ack_vld(ack_vld), .ack(ack), .busy(busy),
    .locked(locked), .rd_data(rd_data)
  );

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  logic [7:0] pm [32];
  bit lk_m = 0;
  logic [7:0] tx [64];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  function automatic bit exp_ack(input bit match, input bit islock, input int i, input bit wcv);
    return match && !wcv && !lk_m && (!islock || i == 0);
  endfunction

  task automatic check_page(input string req);
    for (int a = 0; a < 32; a++) begin
      @(negedge clk) rd_addr = 5'(a);
      @(negedge clk);
      chk(rd_data == pm[a], req, rd_data, pm[a]);
    end
  endtask

  // One command: select, address, n data bytes from tx, Stop.
  task automatic run_cmd(input logic [3:0] typ, input bit rd, input logic [7:0] hi,
                         input logic [7:0] lo, input int n, input bit slot,
                         input bit wcv, input bit probe);
    bit match = (typ == 4'b1011) && !rd;
    bit islock = hi[2];
    logic [7:0] sb [32];
    bit sm [32];
    int acc = 0;
    bit arm = 0;
    bit commit;
    int len;
    for (int k = 0; k < 32; k++) sm[k] = 0;
    @(negedge clk) sel_vld = 1; sel_type = typ; sel_rd = rd;
    @(negedge clk) sel_vld = 0; addr_vld = 1; addr_hi = hi; addr_lo = lo;
    @(negedge clk) addr_vld = 0; wc = wcv;
    for (int i = 0; i < n; i++) begin
      bit ea = exp_ack(match, islock, i, wcv);
      data_vld = 1; data_byte = tx[i];
      @(negedge clk) data_vld = 0;
      chk(ack_vld == match, "R1/R11 ack_vld", ack_vld, match);
      chk(ack == ea, lk_m ? "R8 ack" : (wcv ? "R9 ack" : "R3 ack"), ack, ea);
      if (ea && !islock) begin
        sb[(lo + acc) % 32] = tx[i]; sm[(lo + acc) % 32] = 1; acc++;
      end
      if (ea && islock) begin acc = 1; arm = tx[0][1]; end
    end
    commit = match && slot && acc > 0;
    stop_det = 1; stop_slot = slot;
    @(negedge clk) stop_det = 0; stop_slot = 0; wc = 0;
    chk(busy == commit, "R4 commit", busy, commit);
    if (commit && probe) begin
      data_vld = 1; data_byte = 8'h5A;
      @(negedge clk) data_vld = 0;
      chk(ack_vld && !ack, "R5 busy nack", {ack_vld, ack}, 2);
      sel_vld = 1; sel_type = 4'b1011; sel_rd = 0;
      @(negedge clk) sel_vld = 0;
    end
    len = 0;
    while (busy) begin len++; @(negedge clk); end
    if (commit && !probe) chk(len == TW, "R5 busy length", len, TW);
    if (commit && !islock)
      for (int k = 0; k < 32; k++) if (sm[k]) pm[k] = sb[k];
    if (commit && islock && arm) lk_m = 1;
    chk(locked == lk_m, islock ? "R6/R7 locked" : "R8 locked", locked, lk_m);
    if (probe) begin
      data_vld = 1;
      @(negedge clk) data_vld = 0;
      chk(!ack_vld, "R5 select ignored", ack_vld, 0);
    end
  endtask

  initial begin
    int seed_v;
    seed_v = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!ack_vld && !ack && !busy && !locked, "R10 reset", {ack_vld, ack, busy, locked}, 0);

    // R2: full page from 0, unrelated high bits set, A10 clear
    for (int i = 0; i < 32; i++) tx[i] = 8'(i * 7 + 3);
    run_cmd(4'b1011, 0, 8'hFB, 8'hE0, 32, 1, 0, 0);
    check_page("R2 full page");

    // R3: wrap from position 30
    for (int i = 0; i < 4; i++) tx[i] = 8'hC0 + 8'(i);
    run_cmd(4'b1011, 0, 8'h00, 8'h1E, 4, 1, 0, 0);
    check_page("R3 wrap");

    // R4: Stop outside slot discards
    tx[0] = 8'h99;
    run_cmd(4'b1011, 0, 8'h00, 8'h05, 1, 0, 0, 0);
    check_page("R4 discard");

    // R5: probe busy window
    tx[0] = 8'h42;
    run_cmd(4'b1011, 0, 8'h00, 8'h09, 1, 1, 0, 1);
    check_page("R5 probe page");

    // random page writes before lock
    for (int it = 0; it < 25; it++) begin
      int n = 1 + int'($urandom_range(0, 39));
      for (int i = 0; i < n; i++) tx[i] = 8'($urandom);
      run_cmd(($urandom_range(0, 4) == 0) ? 4'b1010 : 4'b1011,
              $urandom_range(0, 9) == 0, 8'($urandom) & 8'hFB, 8'($urandom),
              n, $urandom_range(0, 9) != 0, $urandom_range(0, 6) == 0, 0);
    end
    check_page("R3 random");

    // R7: lock byte with bit 1 clear
    tx[0] = 8'hFD;
    run_cmd(4'b1011, 0, 8'h04, 8'h00, 1, 1, 0, 0);
    // R9: valid lock byte under write control
    tx[0] = 8'h02;
    run_cmd(4'b1011, 0, 8'h04, 8'h00, 1, 1, 1, 0);
    // R6: valid lock, extra byte refused (R11)
    tx[0] = 8'h02; tx[1] = 8'hFF;
    run_cmd(4'b1011, 0, 8'hFF, 8'h3C, 2, 1, 0, 0);
    chk(locked == 1, "R6 locked set", locked, 1);

    // R8: page write and relock after lock
    for (int i = 0; i < 8; i++) tx[i] = 8'hEE;
    run_cmd(4'b1011, 0, 8'h00, 8'h00, 8, 1, 0, 0);
    tx[0] = 8'h02;
    run_cmd(4'b1011, 0, 8'h04, 8'h00, 1, 1, 0, 0);
    for (int it = 0; it < 6; it++) begin
      int n = 1 + int'($urandom_range(0, 31));
      for (int i = 0; i < n; i++) tx[i] = 8'($urandom);
      run_cmd(4'b1011, 0, 8'($urandom), 8'($urandom), n, 1, 0, 0);
    end
    check_page("R8 page unchanged");
    chk(locked == 1, "R8 sticky", locked, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule